// File: doc/BRIEF.md
# Transmit Channel Delay Adjuster

This block adds a programmable delay to one transmit upconverter output path so that several transmit channels can be lined up in time. Complex samples (18-bit I and 18-bit Q) arrive on every transmit clock. A phase counter runs from 0 up to a programmable limit, so the sample rate drops by that limit plus one. Only the sample that arrives while the phase matches the fine offset is kept. Changing the fine offset therefore moves the output in steps of one transmit clock.

Each kept sample is written into a 64-entry circular store. The read address lags the write address by a programmable coarse offset, so a sample comes out that many output sample times after it was taken. This gives the coarse delay.

A sync input forces the phase counter back to zero. Channels that receive the same sync pulse then decimate in lockstep.

Top module: `tdly_adjust`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_vld` = 0, `out_i` = 0, `out_q` = 0, phase 0 and write pointer 0.
- R2: Without sync, the phase counter steps 0, 1, …, `decim_sel` and then wraps to 0. One sample is kept every `decim_sel`+1 clocks, so `out_vld` pulses once per period.
- R3: `out_vld` is high in the cycle after a clock in which the phase equals the effective fine offset, and is low in every other cycle.
- R4: A `fine_ofs` larger than `decim_sel` acts as `decim_sel`.
- R5: The sample on `in_i`/`in_q` in a kept clock is the k-th kept sample. With coarse offset c it appears on `out_i`/`out_q`, with `out_vld` high, at output strobe k+c. With c = 0 it appears one clock after it is kept.
- R6: Write and read pointers are 6 bits wide and wrap modulo 64. The read address is the write address minus `coarse_ofs`, and any offset from 0 to 63 gives exactly that delay.
- R7: When `sync_in` is high at a clock edge, the phase is 0 in the following cycle.
- R8: A new `coarse_ofs` is applied at the very next output strobe. That strobe returns the sample written `coarse_ofs` strobes earlier.
- R9: `out_i` and `out_q` hold their value in every cycle in which `out_vld` is low.
- R10: If the phase is at or above `decim_sel`, for example after `decim_sel` has been lowered, the phase returns to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Restarts the decimation phase at 0 |
| decim_sel | input | 3 | Decimation factor minus one |
| fine_ofs | input | 3 | Phase in which a sample is kept (fine delay) |
| coarse_ofs | input | 6 | Delay in output samples between write and read |
| in_i | input | 18 | In-phase input sample |
| in_q | input | 18 | Quadrature input sample |
| out_vld | output | 1 | Output sample strobe |
| out_i | output | 18 | Delayed in-phase sample |
| out_q | output | 18 | Delayed quadrature sample |

## Verification
The keep decision is made in the clock where the phase matches. The strobe and the selected sample are both registered, so `out_vld` and the data are due exactly one clock later. The phase reacts to sync or a wrap on the clock right after the edge that saw it.

The bench drives inputs on the falling edge. Its reference model updates on the rising edge, and the model and the design outputs are compared at the next falling edge, so every result is checked in the cycle it is due. Data is compared only once the model has written the sample that the coarse offset selects. Until then the store holds nothing defined.

// File: rtl/tdly_pkg.sv
package tdly_pkg;

    localparam int SAMP_W = 18;

    typedef int unsigned uint_t;

    typedef struct packed {
        logic [SAMP_W-1:0] re;
        logic [SAMP_W-1:0] im;
    } iq_t;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_WRAP = 2'd1,
        PH_SYNC = 2'd2
    } ph_act_e;

    // A fine offset beyond the decimation limit would never match; pin it to the limit.
    function automatic uint_t eff_phase(input uint_t fine, input uint_t lim);
        return (fine > lim) ? lim : fine;
    endfunction

endpackage

// File: rtl/tdly_phase.sv
module tdly_phase
    import tdly_pkg::*;
#(
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_in,
    input  logic [PH_W-1:0] decim_sel,
    input  logic [PH_W-1:0] fine_ofs,
    output logic [PH_W-1:0] phase_q,
    output logic            keep
);
    ph_act_e         act;
    logic [PH_W-1:0] fine_eff;

    always_comb begin
        fine_eff = PH_W'(eff_phase(uint_t'(fine_ofs), uint_t'(decim_sel)));
        keep     = (phase_q == fine_eff);
        if (sync_in)
            act = PH_SYNC;
        else if (phase_q >= decim_sel)
            act = PH_WRAP;
        else
            act = PH_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            unique case (act)
                PH_SYNC: phase_q <= '0;
                PH_WRAP: phase_q <= '0;
                default: phase_q <= phase_q + PH_W'(1);
            endcase
        end
    end
endmodule

// File: rtl/tdly_ring.sv
module tdly_ring
    import tdly_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  iq_t               wr_data,
    input  logic [ADDR_W-1:0] coarse,
    output iq_t               rd_data,
    output logic [ADDR_W-1:0] wptr_q
);
    localparam int DEPTH = 1 << ADDR_W;

    iq_t               store [DEPTH];
    logic [ADDR_W-1:0] rd_addr;

    always_ff @(posedge clk) begin
        if (rst)
            wptr_q <= '0;
        else if (wr_en)
            wptr_q <= wptr_q + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            store[wptr_q] <= wr_data;
    end

    always_comb begin
        rd_addr = wptr_q - coarse;
        rd_data = (coarse == '0) ? wr_data : store[rd_addr];
    end
endmodule

// File: rtl/tdly_outreg.sv
module tdly_outreg
    import tdly_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  iq_t  din,
    output logic vld_q,
    output iq_t  dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dout  <= '0;
        end else begin
            vld_q <= load;
            if (load)
                dout <= din;
        end
    end
endmodule

// File: rtl/tdly_adjust.sv
module tdly_adjust
    import tdly_pkg::*;
#(
    parameter int PH_W   = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic [PH_W-1:0]   decim_sel,
    input  logic [PH_W-1:0]   fine_ofs,
    input  logic [ADDR_W-1:0] coarse_ofs,
    input  logic [SAMP_W-1:0] in_i,
    input  logic [SAMP_W-1:0] in_q,
    output logic              out_vld,
    output logic [SAMP_W-1:0] out_i,
    output logic [SAMP_W-1:0] out_q
);
    logic [PH_W-1:0]   phase_q;
    logic              keep;
    logic [ADDR_W-1:0] wptr_q;
    iq_t               smp_in;
    iq_t               smp_rd;
    iq_t               smp_out;

    assign smp_in = '{re: in_i, im: in_q};

    tdly_phase #(.PH_W(PH_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .decim_sel (decim_sel),
        .fine_ofs  (fine_ofs),
        .phase_q   (phase_q),
        .keep      (keep)
    );

    tdly_ring #(.ADDR_W(ADDR_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (keep),
        .wr_data (smp_in),
        .coarse  (coarse_ofs),
        .rd_data (smp_rd),
        .wptr_q  (wptr_q)
    );

    tdly_outreg u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (keep),
        .din   (smp_rd),
        .vld_q (out_vld),
        .dout  (smp_out)
    );

    assign out_i = smp_out.re;
    assign out_q = smp_out.im;
endmodule

// File: rtl/tdly_adjust_chk.sv
module tdly_adjust_chk #(
    parameter int PH_W   = 3,
    parameter int ADDR_W = 6,
    parameter int DW     = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic [PH_W-1:0]   decim_sel,
    input logic [PH_W-1:0]   fine_ofs,
    input logic [PH_W-1:0]   phase,
    input logic              keep,
    input logic [ADDR_W-1:0] wptr,
    input logic              out_vld,
    input logic [DW-1:0]     out_i,
    input logic [DW-1:0]     out_q
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_vld && out_i == '0 && out_q == '0 && phase == '0 && wptr == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && phase < decim_sel) |=> phase == $past(phase) + PH_W'(1));

    assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && phase >= decim_sel) |=> phase == '0);

    assert_sync_R7: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> phase == '0);

    assert_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(keep));

    assert_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (keep && fine_ofs > decim_sel) |-> phase == decim_sel);

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> wptr == ADDR_W'($past(wptr) + ADDR_W'(1)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind tdly_adjust tdly_adjust_chk #(.PH_W(PH_W), .ADDR_W(ADDR_W), .DW(tdly_pkg::SAMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_in   (sync_in),
    .decim_sel (decim_sel),
    .fine_ofs  (fine_ofs),
    .phase     (phase_q),
    .keep      (keep),
    .wptr      (wptr_q),
    .out_vld   (out_vld),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/tdly_adjust_bench.sv
module tdly_adjust_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_in = 1'b0;
    logic [2:0]  decim_sel = 3'd3;
    logic [2:0]  fine_ofs = 3'd0;
    logic [5:0]  coarse_ofs = 6'd0;
    logic [17:0] in_i = '0;
    logic [17:0] in_q = '0;
    logic        out_vld;
    logic [17:0] out_i;
    logic [17:0] out_q;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    cmp_en = 0;
    string cur_req = "R1";
    int unsigned seed = 32'h1234_5678;

    // reference model state
    int          m_ph = 0;
    int          m_wcnt = 0;
    bit          m_vld = 0;
    bit          m_known = 1;
    logic [35:0] m_dat = '0;
    logic [35:0] hist [int];
    int          vld_count = 0;

    always #10 clk = ~clk;

    tdly_adjust u_tdly_adjust (
        .clk(clk), .rst(rst), .sync_in(sync_in), .decim_sel(decim_sel),
        .fine_ofs(fine_ofs), .coarse_ofs(coarse_ofs), .in_i(in_i), .in_q(in_q),
        .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_wcnt = 0; m_vld = 0; m_known = 1; m_dat = '0;
        end else begin
            int eff;
            int rd;
            eff = (int'(fine_ofs) > int'(decim_sel)) ? int'(decim_sel) : int'(fine_ofs);
            m_vld = (m_ph == eff);
            if (m_vld) begin
                hist[m_wcnt] = {in_i, in_q};
                rd = m_wcnt - int'(coarse_ofs);
                if (rd >= 0) begin
                    m_dat = hist[rd];
                    m_known = 1;
                end else begin
                    m_known = 0;
                end
                m_wcnt++;
            end
            if (sync_in || m_ph >= int'(decim_sel)) m_ph = 0;
            else m_ph = m_ph + 1;
        end
    end

    task automatic check(input string req, input bit ok, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cmp_en) begin
                check(cur_req, out_vld == m_vld, "out_vld", 36'(out_vld), 36'(m_vld));
                if (out_vld) vld_count++;
                // R5 R9: data compared whenever the model knows the selected sample
                if (m_known)
                    check(cur_req, {out_i, out_q} == m_dat, "data", {out_i, out_q}, m_dat);
            end
            seed = seed * 32'd1103515245 + 32'd12345;
            in_i = seed[31:14];
            seed = seed * 32'd1103515245 + 32'd12345;
            in_q = seed[31:14];
            sync_in = 1'b0;
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        check(cur_req, out_vld == m_vld, "out_vld", 36'(out_vld), 36'(m_vld));
        sync_in = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check("R1", out_vld == 1'b0, "out_vld in reset", 36'(out_vld), 36'd0);
        check("R1", {out_i, out_q} == '0, "data in reset", {out_i, out_q}, 36'd0);
        rst = 1'b0;
        cmp_en = 1;

        // R2 R5: decimate by 4, zero coarse delay
        cur_req = "R2";
        step(40);
        pulse_sync();
        step(1);
        vld_count = 0;
        step(80);
        check("R2", vld_count == 20, "strobes in 80 clocks", 36'(vld_count), 36'd20);

        cur_req = "R5";
        coarse_ofs = 6'd5;
        step(200);

        // R3 R7: fine offset and sync realignment
        cur_req = "R3";
        fine_ofs = 3'd2;
        step(50);
        cur_req = "R7";
        step(2); pulse_sync(); step(30);
        step(1); pulse_sync(); step(30);

        // R6: deepest delay, widest decimation, pointer wrap
        cur_req = "R6";
        decim_sel = 3'd7; fine_ofs = 3'd7; coarse_ofs = 6'd63;
        step(1200);

        // R4: fine offset above the limit
        cur_req = "R4";
        decim_sel = 3'd2; fine_ofs = 3'd6; coarse_ofs = 6'd3;
        step(120);

        // R8: coarse offset changes between strobes
        cur_req = "R8";
        decim_sel = 3'd1; fine_ofs = 3'd1;
        coarse_ofs = 6'd10; step(41);
        coarse_ofs = 6'd2;  step(23);
        coarse_ofs = 6'd0;  step(17);
        coarse_ofs = 6'd40; step(60);

        // R10: limit lowered while the phase is high
        cur_req = "R10";
        decim_sel = 3'd7; fine_ofs = 3'd0; coarse_ofs = 6'd1;
        pulse_sync(); step(7);
        decim_sel = 3'd1;
        step(40);

        // R9: held data covered by every compare above; long idle gaps here
        cur_req = "R9";
        decim_sel = 3'd7; fine_ofs = 3'd4; coarse_ofs = 6'd0;
        step(100);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule